// File: doc/BRIEF.md
# CEC Opcode Wake Matcher

This block watches completed incoming CEC frames and decides whether a frame should wake the host. Each frame arrives as one transfer: a strobe, the count of bytes that follow the header, and the first of those bytes, which is the opcode. The opcode is compared in parallel against a table of eight programmable one-byte entries. Every entry that matches sets its own bit in a sticky 8-bit status register. A separate 8-bit enable register selects which status bits may raise the single interrupt line.

The table, the enable register and the status clear are written through plain register strobes. The table comes out of reset holding eight standard opcodes that all expect a reply from the receiver. A host can therefore take wake-ups for common queries without programming anything, and can retarget any entry later. Frame reception and the CEC line itself are handled by other blocks.

The frame input is a valid/ready stream. `frm_ready` is held high at all times, so the block never applies back-pressure, and one frame is taken on every rising clock edge where `frm_valid` is high. The sender may hold `frm_valid` high on consecutive cycles, and each cycle then counts as a separate frame.

Top module: `cec_wake_match`

## Requirements
- R1: After reset the table holds these entries, by index 0 to 7: 0x8F, 0x83, 0x46, 0x8C, 0x9F, 0x91, 0x08, 0x1A. After reset the enable register, the status register and `wake_irq` are all zero.
- R2: When `tbl_we` is high at a clock edge, `tbl_wdata` is stored into entry `tbl_addr`. `tbl_rdata` always shows the current contents of entry `tbl_addr`.
- R3: A frame taken with `frm_len` of 1 or more sets status bit N at that same edge when `frm_opcode` equals entry N. An opcode found in no entry changes nothing.
- R4: A frame with `frm_len` equal to 0, which is a header-only poll, never sets a status bit, whatever its opcode.
- R5: When several entries hold the same opcode, a matching frame sets all of their bits at the same edge.
- R6: Status bits are sticky. Later frames, whether they match or not, never clear a bit that is already set.
- R7: When `clr_we` is high at an edge, every status bit whose `clr_mask` bit is 1 is cleared. Bits whose mask bit is 0 keep their value.
- R8: When a match and a clear hit the same status bit at the same edge, the bit ends up set.
- R9: `en_we` loads `en_wdata` into the enable register, which is visible on `wake_en`. `wake_irq` is high exactly when some status bit is set and its enable bit is also set. Status bits set whatever the enable value is.
- R10: `frm_ready` is always 1. No frame is taken on a cycle where `frm_valid` is low.
- R11: When a table write and a frame land on the same edge, the frame is compared against the table contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | Completed frame is offered |
| frm_ready | output | 1 | Frame accepted; always 1 |
| frm_len | input | 5 | Number of bytes after the header |
| frm_opcode | input | 8 | First byte after the header |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_addr | input | 3 | Table entry index, used for both write and read |
| tbl_wdata | input | 8 | Opcode to store |
| tbl_rdata | output | 8 | Contents of entry `tbl_addr` |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | New enable mask |
| wake_en | output | 8 | Current enable mask |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 8 | Write-one-to-clear mask |
| wake_status | output | 8 | Sticky match status |
| wake_irq | output | 1 | Combined masked interrupt |

## Verification
Two functions can meet in a single cycle: a frame that sets a status bit, and a host clear aimed at that same bit. The bench drives both on one edge, in two setups. In the first the bit starts clear and the clear targets only that bit. In the second a neighbouring bit is already set and the mask covers both bits. The result is judged correct only if the matched bit stays set while the neighbour is cleared. A table write that coincides with a frame is provoked the same way, and the frame must be compared against the old entry, not the new one.

// File: rtl/cec_wake_pkg.sv
package cec_wake_pkg;

  localparam int OPC_W = 8;

  // Reset contents of the table: opcodes that expect a reply.
  function automatic logic [OPC_W-1:0] dflt_opc(input int unsigned idx);
    logic [OPC_W-1:0] v;
    case (idx)
      0:       v = 8'h8F; // power status query
      1:       v = 8'h83; // physical address query
      2:       v = 8'h46; // name query
      3:       v = 8'h8C; // vendor id query
      4:       v = 8'h9F; // version query
      5:       v = 8'h91; // menu language query
      6:       v = 8'h08; // tuner status query
      7:       v = 8'h1A; // deck status query
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cec_opc_table.sv
module cec_opc_table #(
  parameter int N_ENT = 8,
  parameter int OPC_W = 8,
  localparam int AW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [OPC_W-1:0] wr_data,
  output logic [OPC_W-1:0] rd_data,
  input  logic             cmp_en,
  input  logic [OPC_W-1:0] cmp_opc,
  output logic [N_ENT-1:0] hit_vec
);
  import cec_wake_pkg::*;

  logic [OPC_W-1:0] entry_q [N_ENT];

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry_q[i] <= OPC_W'(dflt_opc(i));
      else if (wr_en && (addr == AW'(i)))
        entry_q[i] <= wr_data;
    end
    // compare against the registered value: a same-edge write is not seen
    assign hit_vec[i] = cmp_en && (entry_q[i] == cmp_opc);
  end

  assign rd_data = entry_q[addr];

  // R2
  tbl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (entry_q[$past(addr)] == $past(wr_data)));

endmodule

// File: rtl/cec_wake_status.sv
module cec_wake_status #(
  parameter int N_ENT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ENT-1:0] hit_vec,
  input  logic             clr_we,
  input  logic [N_ENT-1:0] clr_mask,
  input  logic             en_we,
  input  logic [N_ENT-1:0] en_wdata,
  output logic [N_ENT-1:0] sts_q,
  output logic [N_ENT-1:0] en_q,
  output logic             irq
);

  logic [N_ENT-1:0] clr_eff;
  logic [N_ENT-1:0] sts_d;

  assign clr_eff = clr_we ? clr_mask : '0;
  // a new hit wins over a clear of the same bit
  assign sts_d   = (sts_q & ~clr_eff) | hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      if (en_we) en_q <= en_wdata;
    end
  end

  assign irq = |(sts_q & en_q);

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(sts_q) & ~$past(clr_eff)) & ~sts_q) == '0));

  // R3 R8
  hit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(hit_vec) & ~sts_q) == '0));

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

endmodule

// File: rtl/cec_wake_match.sv
module cec_wake_match #(
  parameter int N_ENT = 8,
  parameter int OPC_W = 8,
  parameter int LEN_W = 5,
  localparam int AW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  output logic             frm_ready,
  input  logic [LEN_W-1:0] frm_len,
  input  logic [OPC_W-1:0] frm_opcode,
  input  logic             tbl_we,
  input  logic [AW-1:0]    tbl_addr,
  input  logic [OPC_W-1:0] tbl_wdata,
  output logic [OPC_W-1:0] tbl_rdata,
  input  logic             en_we,
  input  logic [N_ENT-1:0] en_wdata,
  output logic [N_ENT-1:0] wake_en,
  input  logic             clr_we,
  input  logic [N_ENT-1:0] clr_mask,
  output logic [N_ENT-1:0] wake_status,
  output logic             wake_irq
);

  logic             frm_take;
  logic             frm_qual;
  logic [N_ENT-1:0] hit_vec;

  assign frm_ready = 1'b1;
  assign frm_take  = frm_valid && frm_ready;
  // header-only polls carry no opcode
  assign frm_qual  = frm_take && (frm_len != '0);

  cec_opc_table #(.N_ENT(N_ENT), .OPC_W(OPC_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we),
    .addr    (tbl_addr),
    .wr_data (tbl_wdata),
    .rd_data (tbl_rdata),
    .cmp_en  (frm_qual),
    .cmp_opc (frm_opcode),
    .hit_vec (hit_vec)
  );

  cec_wake_status #(.N_ENT(N_ENT)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_vec  (hit_vec),
    .clr_we   (clr_we),
    .clr_mask (clr_mask),
    .en_we    (en_we),
    .en_wdata (en_wdata),
    .sts_q    (wake_status),
    .en_q     (wake_en),
    .irq      (wake_irq)
  );

  // R4 R10
  no_poll_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_valid && (frm_len != '0)) |-> (hit_vec == '0));

endmodule

// File: tb/tb_cec_wake_match.sv
module tb_cec_wake_match;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frm_valid = 1'b0;
  logic       frm_ready;
  logic [4:0] frm_len = '0;
  logic [7:0] frm_opcode = '0;
  logic       tbl_we = 1'b0;
  logic [2:0] tbl_addr = '0;
  logic [7:0] tbl_wdata = '0;
  logic [7:0] tbl_rdata;
  logic       en_we = 1'b0;
  logic [7:0] en_wdata = '0;
  logic [7:0] wake_en;
  logic       clr_we = 1'b0;
  logic [7:0] clr_mask = '0;
  logic [7:0] wake_status;
  logic       wake_irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] dflt [8] = '{8'h8F, 8'h83, 8'h46, 8'h8C, 8'h9F, 8'h91, 8'h08, 8'h1A};

  always #2 clk = ~clk;

  cec_wake_match dut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [4:0] len, input logic [7:0] opc);
    @(negedge clk);
    frm_valid = 1'b1; frm_len = len; frm_opcode = opc;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic clear(input logic [7:0] m);
    @(negedge clk);
    clr_we = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic wr_tbl(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status after reset", wake_status, 8'h00);
    chk("R1 enable after reset", wake_en, 8'h00);
    chk("R1 irq after reset", wake_irq, 1'b0);
    chk("R10 ready", frm_ready, 1'b1);
  endtask

  task automatic t_defaults();
    for (int i = 0; i < 8; i++) begin
      tbl_addr = 3'(i);
      #1;
      chk("R1 default entry", tbl_rdata, dflt[i]);
    end
  endtask

  task automatic t_basic();
    send(5'd3, 8'h83);
    chk("R3 match entry 1", wake_status, 8'h02);
    clear(8'hFF);
    send(5'd1, 8'h1A);
    chk("R3 match entry 7", wake_status, 8'h80);
    clear(8'hFF);
    send(5'd2, 8'h55);
    chk("R3 no match", wake_status, 8'h00);
  endtask

  task automatic t_poll_and_idle();
    send(5'd0, 8'h8F);
    chk("R4 header-only frame", wake_status, 8'h00);
    @(negedge clk);
    frm_valid = 1'b0; frm_len = 5'd1; frm_opcode = 8'h8F;
    @(negedge clk);
    chk("R10 valid low ignored", wake_status, 8'h00);
  endtask

  task automatic t_dup();
    wr_tbl(3'd5, 8'h8F);
    tbl_addr = 3'd5; #1;
    chk("R2 readback entry 5", tbl_rdata, 8'h8F);
    send(5'd1, 8'h8F);
    chk("R5 duplicate entries", wake_status, 8'h21);
    clear(8'hFF);
    chk("R7 clear all", wake_status, 8'h00);
  endtask

  task automatic t_sticky_clear();
    send(5'd1, 8'h83);
    send(5'd4, 8'h46);
    chk("R6 accumulate", wake_status, 8'h06);
    send(5'd1, 8'h55);
    chk("R6 sticky after miss", wake_status, 8'h06);
    clear(8'h02);
    chk("R7 partial clear", wake_status, 8'h04);
    clear(8'hFF);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    frm_valid = 1'b1; frm_len = 5'd1; frm_opcode = 8'h83;
    clr_we = 1'b1; clr_mask = 8'h02;
    @(negedge clk);
    frm_valid = 1'b0; clr_we = 1'b0; clr_mask = '0;
    chk("R8 match beats clear", wake_status, 8'h02);
    clear(8'hFF);
    send(5'd1, 8'h46);
    @(negedge clk);
    frm_valid = 1'b1; frm_len = 5'd2; frm_opcode = 8'h83;
    clr_we = 1'b1; clr_mask = 8'h06;
    @(negedge clk);
    frm_valid = 1'b0; clr_we = 1'b0; clr_mask = '0;
    chk("R8 neighbour cleared, hit kept", wake_status, 8'h02);
  endtask

  task automatic t_irq();
    chk("R9 no irq with zero enable", wake_irq, 1'b0);
    @(negedge clk); en_we = 1'b1; en_wdata = 8'h04;
    @(negedge clk); en_we = 1'b0;
    chk("R9 enable readback", wake_en, 8'h04);
    chk("R9 masked bit no irq", wake_irq, 1'b0);
    @(negedge clk); en_we = 1'b1; en_wdata = 8'h02;
    @(negedge clk); en_we = 1'b0;
    chk("R9 irq on enabled bit", wake_irq, 1'b1);
    clear(8'h02);
    chk("R9 irq drops after clear", wake_irq, 1'b0);
  endtask

  task automatic t_write_vs_frame();
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 3'd1; tbl_wdata = 8'h44;
    frm_valid = 1'b1; frm_len = 5'd1; frm_opcode = 8'h83;
    @(negedge clk);
    tbl_we = 1'b0; frm_valid = 1'b0;
    chk("R11 old entry used", wake_status, 8'h02);
    clear(8'hFF);
    send(5'd1, 8'h83);
    chk("R11 old opcode gone", wake_status, 8'h00);
    send(5'd1, 8'h44);
    chk("R2 new opcode matches", wake_status, 8'h02);
  endtask

  initial begin
    #50000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_defaults();
    t_basic();
    t_poll_and_idle();
    t_dup();
    t_sticky_clear();
    t_same_cycle();
    t_irq();
    t_write_vs_frame();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule